// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry

This block holds the architectural register state of a small processor core that runs in several privilege modes. The core sees sixteen general registers, of which index 15 is the program counter. Some of those registers are backed by separate storage for each mode. The core reads them through two combinational ports and writes them through one port. The program counter advances from a next-PC input.

The block also keeps the current program status word and one saved status word for each exception mode. It carries out a complete exception entry in a single clock edge. That entry writes the return link, switches the mode, masks interrupts and loads the vector into the program counter. The instruction decoder uses the block's status-write port to apply move-to-status instructions. The interrupt logic reads the block's pending fast-interrupt output.

Top module: `modal_regfile`

## Requirements
- R1: After reset the status word reads 0x00000053: supervisor mode 0x13, bit 6 (fast interrupt disable) set, bit 7 (interrupt disable) clear, and flags bits 31:28 clear. The saved-status output reads 0 and r15 reads 0. The stack register r13 reads 0x03007FE0 in supervisor mode, 0x03007FA0 in IRQ mode (0x12) and 0x03007F00 in system or user mode (0x1F/0x10).
- R2: Registers r0-r7 and r15 are a single copy seen by every mode. Registers r8-r12 are shared by all modes except fast-interrupt mode (0x11), which has its own copies.
- R3: Registers r13 and r14 have one copy per mode group: user/system, fast interrupt, IRQ, supervisor, abort (0x17) and undefined (0x1B). User and system share one copy.
- R4: A read during a cycle that commits a mode change returns the register of the bank that the new mode selects.
- R5: A fast-interrupt request (exc_fiq) enters mode 0x11 and sets bits 7 and 6. It copies the old status word into that mode's saved status, writes next_pc+4 to r14 of the new bank and loads 0x1C into r15.
- R6: A software-interrupt request enters supervisor mode and sets bit 7, leaving bit 6 unchanged. It saves the old status word, writes next_pc+4 to r14 and loads 0x08 into r15.
- R7: An undefined-instruction request enters mode 0x1B and sets bit 7. It saves the old status word, writes next_pc+4 to r14 and loads 0x04 into r15.
- R8: When several requests arrive together, fast interrupt wins over undefined, and undefined wins over software interrupt. An exception cancels a status write in the same cycle. It also overrides a general write to r14 or r15.
- R9: A current-status write made in user mode changes only bits 31:24.
- R10: A current-status write made in a privileged mode changes bits 31:24 and 7:0, with bit 4 forced to 1. It switches the register bank to the new mode and leaves every saved status word alone.
- R11: A privileged current-status write whose mode field (after bit 4 is forced) is not one of 0x10, 0x11, 0x12, 0x13, 0x17, 0x1B or 0x1F changes nothing. It drives mode_err high during that cycle.
- R12: spsr_o shows the saved status word of the current mode, and reads 0 in user and system modes. A saved-status write takes effect only in modes 0x11, 0x12, 0x13, 0x17 or 0x1B, and it changes only bits 31:24 and 7:0.
- R13: fiq_pending is high when fiq_req is high and bit 6 of the registered status word is clear.
- R14: pc_adv loads next_pc into r15. A general write to r15 in the same cycle wins over pc_adv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 4 | Read port A register index |
| rd_a_data | output | XLEN | Read port A data, bank of the mode after this cycle |
| rd_b_addr | input | 4 | Read port B register index |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | 4 | General write register index |
| wr_data | input | XLEN | General write data |
| pc_adv | input | 1 | Load next_pc into r15 |
| next_pc | input | XLEN | Next-instruction address; the link base for exceptions |
| exc_fiq | input | 1 | Take fast-interrupt entry |
| exc_und | input | 1 | Take undefined-instruction entry |
| exc_swi | input | 1 | Take software-interrupt entry |
| psr_we | input | 1 | Status write enable |
| psr_sel_spsr | input | 1 | 1: write saved status, 0: write current status |
| psr_wdata | input | 32 | Status write value |
| fiq_req | input | 1 | External fast-interrupt request level |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status word of the current mode |
| fiq_pending | output | 1 | Fast-interrupt request that is not masked |
| mode_err | output | 1 | Illegal mode code in this cycle's status write |

## Verification
The bench switches between banks and checks that the r8-r12 values written in fast-interrupt mode never leak into supervisor mode. A design that decoded the bank from the old mode would return the stale stack register during the cycle that changes the mode. The bench also fires all three exception requests together with a status write and a conflicting r14 write. A wrong priority order would leave the wrong mode, vector or link value. Status writes in user mode carry junk in the low byte. Writes with an illegal mode code check that mode_err fires and that the status words stay unchanged, so a design that switched banks on a bad code would fail those checks.

// File: rtl/modal_rf_pkg.sv
`timescale 1ns/1ps
package modal_rf_pkg;

  localparam int NARCH     = 16;
  localparam int PSR_W     = 32;
  localparam int FIQ_LO    = 8;
  localparam int FIQ_CNT   = 5;
  localparam int NBANK     = 6;
  localparam int R_SP      = 13;
  localparam int R_LR      = 14;
  localparam int R_PC      = 15;

  // physical layout: shared low regs, two copies of r8-r12, per-bank sp, per-bank lr, pc
  localparam int IDX_SP_BASE = FIQ_LO + 2 * FIQ_CNT;
  localparam int IDX_LR_BASE = IDX_SP_BASE + NBANK;
  localparam int IDX_PC      = IDX_LR_BASE + NBANK;
  localparam int NPHYS       = IDX_PC + 1;
  localparam int PIDX_W      = $clog2(NPHYS);

  typedef logic [PIDX_W-1:0] pidx_t;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] M_USR = 5'h10;
  localparam logic [4:0] M_FIQ = 5'h11;
  localparam logic [4:0] M_IRQ = 5'h12;
  localparam logic [4:0] M_SVC = 5'h13;
  localparam logic [4:0] M_ABT = 5'h17;
  localparam logic [4:0] M_UND = 5'h1B;
  localparam logic [4:0] M_SYS = 5'h1F;

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;

  localparam logic [7:0] VEC_UND = 8'h04;
  localparam logic [7:0] VEC_SWI = 8'h08;
  localparam logic [7:0] VEC_FIQ = 8'h1C;

  localparam logic [PSR_W-1:0] CPSR_RST = {24'h0, 1'b0, 1'b1, 1'b0, M_SVC};

  function automatic pidx_t phys_of(bank_e b, logic [3:0] r);
    int ri;
    int res;
    ri = int'(r);
    if (ri < FIQ_LO)                 res = ri;
    else if (ri < FIQ_LO + FIQ_CNT)  res = FIQ_LO + ((b == BK_FIQ) ? FIQ_CNT : 0) + (ri - FIQ_LO);
    else if (ri == R_SP)             res = IDX_SP_BASE + int'(b);
    else if (ri == R_LR)             res = IDX_LR_BASE + int'(b);
    else                             res = IDX_PC;
    return pidx_t'(res);
  endfunction

endpackage

// File: rtl/modal_rf_mode_dec.sv
`timescale 1ns/1ps
module modal_rf_mode_dec
  import modal_rf_pkg::*;
(
  input  logic [4:0] code,
  output bank_e      bank,
  output logic       legal,
  output logic       priv
);

  always_comb begin
    bank  = BK_USR;
    legal = 1'b1;
    priv  = 1'b1;
    case (code)
      M_USR: priv = 1'b0;
      M_SYS: bank = BK_USR;
      M_FIQ: bank = BK_FIQ;
      M_IRQ: bank = BK_IRQ;
      M_SVC: bank = BK_SVC;
      M_ABT: bank = BK_ABT;
      M_UND: bank = BK_UND;
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/modal_rf_psr.sv
`timescale 1ns/1ps
module modal_rf_psr
  import modal_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_fiq,
  input  logic             exc_und,
  input  logic             exc_swi,
  input  logic             psr_we,
  input  logic             psr_sel_spsr,
  input  logic [PSR_W-1:0] psr_wdata,
  output logic [PSR_W-1:0] cpsr,
  output logic [PSR_W-1:0] spsr,
  output bank_e            nxt_bank,
  output logic             exc_take,
  output logic [7:0]       exc_vec,
  output logic             mode_err
);

  logic [PSR_W-1:0] cpsr_q, cpsr_d, exc_val, wr_val;
  logic             cpsr_en, cpsr_wr;
  logic [4:0]       exc_mode, nxt_code;
  logic             exc_mask_f;
  bank_e            cur_bank;
  logic             cur_priv;
  logic             req_legal;
  logic [PSR_W-1:0] spsr_all [NBANK];

  logic             cur_legal_unused, req_priv_unused, nxt_legal_unused, nxt_priv_unused;
  bank_e            req_bank_unused;
  logic [15:0]      wdata_mid_unused;
  assign wdata_mid_unused = psr_wdata[23:8];

  modal_rf_mode_dec u_cur_dec (
    .code (cpsr_q[4:0]),
    .bank (cur_bank),
    .legal(cur_legal_unused),
    .priv (cur_priv)
  );

  // exception selection, fixed priority
  always_comb begin
    exc_take   = exc_fiq | exc_und | exc_swi;
    exc_mode   = M_SVC;
    exc_vec    = VEC_SWI;
    exc_mask_f = 1'b0;
    if (exc_fiq) begin
      exc_mode   = M_FIQ;
      exc_vec    = VEC_FIQ;
      exc_mask_f = 1'b1;
    end else if (exc_und) begin
      exc_mode = M_UND;
      exc_vec  = VEC_UND;
    end
    exc_val          = cpsr_q;
    exc_val[4:0]     = exc_mode;
    exc_val[BIT_I]   = 1'b1;
    exc_val[BIT_F]   = cpsr_q[BIT_F] | exc_mask_f;
  end

  // move-to-status on the current word
  always_comb begin
    wr_val         = cpsr_q;
    wr_val[31:24]  = psr_wdata[31:24];
    if (cur_priv) wr_val[7:0] = psr_wdata[7:0];
    wr_val[4]      = 1'b1;
  end

  modal_rf_mode_dec u_req_dec (
    .code (wr_val[4:0]),
    .bank (req_bank_unused),
    .legal(req_legal),
    .priv (req_priv_unused)
  );

  assign cpsr_wr  = psr_we & ~psr_sel_spsr & ~exc_take;
  assign mode_err = cpsr_wr & ~req_legal;
  assign cpsr_en  = exc_take | (cpsr_wr & req_legal);
  assign cpsr_d   = exc_take ? exc_val : wr_val;
  assign nxt_code = cpsr_en ? cpsr_d[4:0] : cpsr_q[4:0];

  modal_rf_mode_dec u_nxt_dec (
    .code (nxt_code),
    .bank (nxt_bank),
    .legal(nxt_legal_unused),
    .priv (nxt_priv_unused)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cpsr_q <= CPSR_RST;
    else if (cpsr_en) cpsr_q <= cpsr_d;
  end

  assign spsr_all[0] = '0;

  for (genvar b = 1; b < NBANK; b++) begin : g_spsr
    logic [PSR_W-1:0] q, d;
    logic             en;
    always_comb begin
      en = 1'b0;
      d  = {psr_wdata[31:24], q[23:8], psr_wdata[7:0]};
      if (exc_take) begin
        en = (nxt_bank == bank_e'(b));
        d  = cpsr_q;
      end else if (psr_we && psr_sel_spsr && cur_bank == bank_e'(b)) begin
        en = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign spsr_all[b] = q;
  end

  assign cpsr = cpsr_q;
  assign spsr = spsr_all[cur_bank];

endmodule

// File: rtl/modal_rf_gpr.sv
`timescale 1ns/1ps
module modal_rf_gpr
  import modal_rf_pkg::*;
#(
  parameter int              XLEN   = 32,
  parameter logic [XLEN-1:0] SP_USR = 'h0300_7F00,
  parameter logic [XLEN-1:0] SP_IRQ = 'h0300_7FA0,
  parameter logic [XLEN-1:0] SP_SVC = 'h0300_7FE0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bank_e           bank,
  input  logic [3:0]      rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            gw_en,
  input  logic [3:0]      gw_addr,
  input  logic [XLEN-1:0] gw_data,
  input  logic            lnk_en,
  input  logic [XLEN-1:0] lnk_data,
  input  logic            pc_en,
  input  logic [XLEN-1:0] pc_data
);

  logic [XLEN-1:0] phys_q [NPHYS];
  pidx_t           gw_idx, lnk_idx, rda_idx, rdb_idx;

  assign gw_idx  = phys_of(bank, gw_addr);
  assign lnk_idx = phys_of(bank, 4'(R_LR));
  assign rda_idx = phys_of(bank, rd_a_addr);
  assign rdb_idx = phys_of(bank, rd_b_addr);

  for (genvar i = 0; i < NPHYS; i++) begin : g_reg
    localparam logic [XLEN-1:0] RV =
      (i == IDX_SP_BASE + int'(BK_USR)) ? SP_USR :
      (i == IDX_SP_BASE + int'(BK_IRQ)) ? SP_IRQ :
      (i == IDX_SP_BASE + int'(BK_SVC)) ? SP_SVC : '0;
    logic [XLEN-1:0] q, d;
    logic            en;
    always_comb begin
      en = gw_en && (gw_idx == pidx_t'(i));
      d  = gw_data;
      if (lnk_en && lnk_idx == pidx_t'(i)) begin
        en = 1'b1;
        d  = lnk_data;
      end
      if (pc_en && (i == IDX_PC)) begin
        en = 1'b1;
        d  = pc_data;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RV;
      else if (en) q <= d;
    end
    assign phys_q[i] = q;
  end

  assign rd_a_data = phys_q[rda_idx];
  assign rd_b_data = phys_q[rdb_idx];

endmodule

// File: rtl/modal_regfile.sv
`timescale 1ns/1ps
module modal_regfile
  import modal_rf_pkg::*;
#(
  parameter int              XLEN   = 32,
  parameter logic [XLEN-1:0] SP_USR = 'h0300_7F00,
  parameter logic [XLEN-1:0] SP_IRQ = 'h0300_7FA0,
  parameter logic [XLEN-1:0] SP_SVC = 'h0300_7FE0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            pc_adv,
  input  logic [XLEN-1:0] next_pc,
  input  logic            exc_fiq,
  input  logic            exc_und,
  input  logic            exc_swi,
  input  logic            psr_we,
  input  logic            psr_sel_spsr,
  input  logic [31:0]     psr_wdata,
  input  logic            fiq_req,
  output logic [31:0]     cpsr_o,
  output logic [31:0]     spsr_o,
  output logic            fiq_pending,
  output logic            mode_err
);

  bank_e           nxt_bank;
  logic            exc_take;
  logic [7:0]      exc_vec;
  logic            wr_pc_hit;
  logic            pc_en;
  logic [XLEN-1:0] pc_data;
  logic [XLEN-1:0] lnk_data;

  modal_rf_psr u_psr (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_fiq     (exc_fiq),
    .exc_und     (exc_und),
    .exc_swi     (exc_swi),
    .psr_we      (psr_we),
    .psr_sel_spsr(psr_sel_spsr),
    .psr_wdata   (psr_wdata),
    .cpsr        (cpsr_o),
    .spsr        (spsr_o),
    .nxt_bank    (nxt_bank),
    .exc_take    (exc_take),
    .exc_vec     (exc_vec),
    .mode_err    (mode_err)
  );

  assign wr_pc_hit = wr_en && (wr_addr == 4'(R_PC));
  assign pc_en     = exc_take || (pc_adv && !wr_pc_hit);
  assign pc_data   = exc_take ? XLEN'(exc_vec) : next_pc;
  assign lnk_data  = next_pc + XLEN'(4);

  modal_rf_gpr #(
    .XLEN  (XLEN),
    .SP_USR(SP_USR),
    .SP_IRQ(SP_IRQ),
    .SP_SVC(SP_SVC)
  ) u_gpr (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank     (nxt_bank),
    .rd_a_addr(rd_a_addr),
    .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr),
    .rd_b_data(rd_b_data),
    .gw_en    (wr_en),
    .gw_addr  (wr_addr),
    .gw_data  (wr_data),
    .lnk_en   (exc_take),
    .lnk_data (lnk_data),
    .pc_en    (pc_en),
    .pc_data  (pc_data)
  );

  assign fiq_pending = fiq_req & ~cpsr_o[BIT_F];

endmodule

// File: rtl/modal_regfile_chk.sv
`timescale 1ns/1ps
module modal_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_fiq,
  input logic        exc_und,
  input logic        exc_swi,
  input logic        psr_we,
  input logic        psr_sel_spsr,
  input logic [31:0] cpsr_o,
  input logic [31:0] spsr_o,
  input logic        fiq_pending,
  input logic        mode_err
);

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_o[4:0] inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F});

  a_r5_fiq_entry: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fiq |=> (cpsr_o[4:0] == 5'h11) && cpsr_o[7] && cpsr_o[6] && (spsr_o == $past(cpsr_o)));

  a_r6_swi_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_swi && !exc_fiq && !exc_und) |=> (cpsr_o[4:0] == 5'h13) && cpsr_o[7]
      && (cpsr_o[6] == $past(cpsr_o[6])) && (spsr_o == $past(cpsr_o)));

  a_r7_und_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_und && !exc_fiq) |=> (cpsr_o[4:0] == 5'h1B) && cpsr_o[7] && (spsr_o == $past(cpsr_o)));

  a_r9_user_write: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && !psr_sel_spsr && cpsr_o[4:0] == 5'h10 && !exc_fiq && !exc_und && !exc_swi)
      |=> cpsr_o[23:0] == $past(cpsr_o[23:0]));

  a_r10_mode_bit4: assert property (@(posedge clk) disable iff (!rst_n) cpsr_o[4]);

  a_r11_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> $stable(cpsr_o) && $stable(spsr_o));

  a_r13_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fiq |=> !fiq_pending);

endmodule

bind modal_regfile modal_regfile_chk u_chk (.*);

// File: tb/modal_regfile_bench.sv
`timescale 1ns/1ps
module modal_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data, next_pc, psr_wdata, cpsr_o, spsr_o;
  logic        wr_en, pc_adv, exc_fiq, exc_und, exc_swi, psr_we, psr_sel_spsr, fiq_req;
  logic        fiq_pending, mode_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  modal_regfile u_modal_regfile (.*);

  // sel, wdata, expected cpsr, expected spsr, expected mode_err
  localparam logic [97:0] VEC [8] = '{
    {1'b0, 32'hF00000D2, 32'hF00000D2, 32'h00000000, 1'b0},
    {1'b1, 32'hA5A5A5A5, 32'hF00000D2, 32'hA50000A5, 1'b0},
    {1'b0, 32'h00000005, 32'hF00000D2, 32'hA50000A5, 1'b1},
    {1'b0, 32'h4000001F, 32'h4000001F, 32'h00000000, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'h4000001F, 32'h00000000, 1'b0},
    {1'b0, 32'h000000D0, 32'h000000D0, 32'h00000000, 1'b0},
    {1'b0, 32'h800000D3, 32'h800000D0, 32'h00000000, 1'b0},
    {1'b0, 32'h00000007, 32'h000000D0, 32'h00000000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    wr_en = 0; wr_addr = 0; wr_data = 0; pc_adv = 0; next_pc = 0;
    exc_fiq = 0; exc_und = 0; exc_swi = 0;
    psr_we = 0; psr_sel_spsr = 0; psr_wdata = 0;
    rd_a_addr = 0; rd_b_addr = 0;
  endtask

  task automatic do_reset();
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_a_addr = a;
    #1;
    v = rd_a_data;
  endtask

  task automatic gwr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic cps(input logic [31:0] d);
    psr_we = 1; psr_sel_spsr = 0; psr_wdata = d;
    cyc();
    psr_we = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    fiq_req = 1'b1;
    do_reset();

    // R1 reset state, R13 masked at reset
    chk("R1 reset cpsr", cpsr_o, 32'h00000053);
    chk("R1 reset spsr", spsr_o, 32'h0);
    chk("R13 pending masked at reset", {31'b0, fiq_pending}, 32'h0);
    rd(4'd15, v); chk("R1 reset pc", v, 32'h0);
    rd(4'd13, v); chk("R1 reset svc sp", v, 32'h03007FE0);

    // table of status writes: R9 R10 R11 R12
    for (int k = 0; k < 8; k++) begin
      psr_we = 1; psr_sel_spsr = VEC[k][97]; psr_wdata = VEC[k][96:65];
      #1;
      chk("R11 mode_err", {31'b0, mode_err}, {31'b0, VEC[k][0]});
      cyc();
      chk("R9 R10 R11 table cpsr", cpsr_o, VEC[k][64:33]);
      chk("R12 table spsr", spsr_o, VEC[k][32:1]);
    end
    psr_we = 0;

    do_reset();

    // banking R2 R3 R4
    gwr(4'd0, 32'h11);
    gwr(4'd8, 32'h88);
    gwr(4'd13, 32'hD13);
    gwr(4'd14, 32'hE14);
    psr_we = 1; psr_sel_spsr = 0; psr_wdata = 32'h00000092;
    rd(4'd13, v); chk("R4 same-cycle read new bank", v, 32'h03007FA0);
    cyc(); psr_we = 0;
    rd(4'd0, v);  chk("R2 r0 shared", v, 32'h11);
    rd_b_addr = 4'd8; #1; chk("R2 r8 shared irq", rd_b_data, 32'h88);
    rd(4'd13, v); chk("R1 irq sp reset", v, 32'h03007FA0);
    cps(32'h0000009F);
    rd(4'd13, v); chk("R1 R3 system sp reset", v, 32'h03007F00);
    gwr(4'd14, 32'h77);
    cps(32'h000000D1);
    rd(4'd8, v);  chk("R2 fiq r8 private", v, 32'h0);
    rd(4'd0, v);  chk("R2 fiq r0 shared", v, 32'h11);
    rd(4'd14, v); chk("R3 fiq lr private", v, 32'h0);
    gwr(4'd8, 32'hF8);
    cps(32'h000000D3);
    rd(4'd8, v);  chk("R2 svc r8 untouched", v, 32'h88);
    rd(4'd13, v); chk("R3 svc sp kept", v, 32'hD13);
    rd(4'd14, v); chk("R3 svc lr kept", v, 32'hE14);
    cps(32'h000000DF);
    rd(4'd14, v); chk("R3 system lr kept", v, 32'h77);

    // exceptions R5 R8 R13
    cps(32'h20000013);
    chk("R13 pending unmasked", {31'b0, fiq_pending}, 32'h1);
    exc_fiq = 1; exc_und = 1; exc_swi = 1; next_pc = 32'h100;
    psr_we = 1; psr_wdata = 32'hF00000D0;
    wr_en = 1; wr_addr = 4'd14; wr_data = 32'hBAD;
    cyc();
    clr();
    chk("R5 R8 fiq cpsr", cpsr_o, 32'h200000D1);
    chk("R5 fiq spsr", spsr_o, 32'h20000013);
    chk("R13 pending after fiq", {31'b0, fiq_pending}, 32'h0);
    rd(4'd15, v); chk("R5 fiq vector", v, 32'h1C);
    rd(4'd14, v); chk("R5 R8 fiq link", v, 32'h104);
    rd(4'd8, v);  chk("R2 fiq r8 kept", v, 32'hF8);

    // R6
    cps(32'h00000013);
    exc_swi = 1; next_pc = 32'h200;
    cyc(); clr();
    chk("R6 swi cpsr", cpsr_o, 32'h00000093);
    chk("R6 swi spsr", spsr_o, 32'h00000013);
    rd(4'd15, v); chk("R6 swi vector", v, 32'h08);
    rd(4'd14, v); chk("R6 swi link", v, 32'h204);

    // R7 with R8 priority over swi
    exc_und = 1; exc_swi = 1; next_pc = 32'h300;
    cyc(); clr();
    chk("R7 R8 und cpsr", cpsr_o, 32'h0000009B);
    chk("R7 und spsr", spsr_o, 32'h00000093);
    rd(4'd15, v); chk("R7 und vector", v, 32'h04);
    rd(4'd14, v); chk("R7 und link", v, 32'h304);

    // R14
    pc_adv = 1; next_pc = 32'h1234;
    cyc(); clr();
    rd(4'd15, v); chk("R14 pc advance", v, 32'h1234);
    pc_adv = 1; next_pc = 32'h9999;
    wr_en = 1; wr_addr = 4'd15; wr_data = 32'h5678;
    cyc(); clr();
    rd(4'd15, v); chk("R14 write beats advance", v, 32'h5678);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule